// File: doc/BRIEF.md
# Reset Sequencer with Source Discrimination

This block gathers reset requests from the whole chip and turns them into one orderly reset sequence. Power-on, low-voltage, illegal-address, watchdog-timeout and clock-monitor requests force the internal reset and the open-drain pin drive at once, through logic alone, with no clock edge needed. A clock-monitor request counts only while self-clock mode is off. A low level seen on the reset pin while the block is idle also starts a sequence, after a two-stage synchronizer.

Leaving reset needs the system clock. The block holds the pin low for a base count of cycles plus a synchronization allowance `SYNC_N`, which must be between 3 and 6. It then releases the pin and waits a settle interval. At the end of that interval it samples the pin. It then combines the sample with two latched flags, clock-monitor pending and watchdog pending, to pick a reset vector code. If the pin is still held low from outside, the block waits for the pin to rise before it releases the internal reset. Any new request during the sequence starts the low-drive count again.

Top module: `reset_sequencer`

## Requirements
- R1: While any of por_i, lvd_i, bad_addr_i or wdog_i is high, or cmon_i is high with self_clk_i low, rst_o and pin_drv_o are both high in the same cycle, before any clock edge.
- R2: A cmon_i request while self_clk_i is high causes no reset and sets no flag. A later reset caused only by bad_addr_i yields vector code 00.
- R3: After the last request is captured, pin_drv_o stays high for exactly LOW_CYC+SYNC_N cycles (131 with the defaults). SYNC_N outside 3..6 is rejected.
- R4: A request that arrives during the low drive, during the settle wait or in the sample cycle restarts the low-drive count. No vector strobe comes out, and the flags already latched are kept.
- R5: After pin_drv_o falls, rst_o stays high for exactly SETTLE_CYC cycles (64 by default) before the sample is taken, provided the pin reads high.
- R6: If the sampled pin is low, the code is 00 whatever the flags hold. rst_o falls on the third clock edge after the pin rises.
- R7: With the pin sampled high and the clock-monitor flag set, the code is 01 whether or not the watchdog flag is set.
- R8: With the pin sampled high, only the watchdog flag set, the code is 10.
- R9: With the pin sampled high and neither flag set, the code is 00.
- R10: vec_vld_o is a one-cycle strobe in the first cycle with rst_o low. vec_sel_o holds the chosen code from then on and is never 11.
- R11: Both flags are cleared when a vector is chosen, so the next sequence sees only its own requests.
- R12: A low pin while the block is idle starts the sequence. pin_drv_o rises on the third clock edge after the pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on request; also clears the flags |
| lvd_i | input | 1 | Low-voltage request |
| bad_addr_i | input | 1 | Illegal-address request |
| wdog_i | input | 1 | Watchdog timeout request |
| cmon_i | input | 1 | Clock-monitor failure |
| self_clk_i | input | 1 | Self-clock mode enabled; masks cmon_i |
| pin_i | input | 1 | Level read back from the reset pin |
| pin_drv_o | output | 1 | High pulls the reset pin low |
| rst_o | output | 1 | Internal reset |
| vec_vld_o | output | 1 | One-cycle strobe when a vector is chosen |
| vec_sel_o | output | 2 | Vector code: 00 general, 01 clock monitor, 10 watchdog |

## Verification
A new request can land in the same cycle as the pin sample and vector release. When that happens the request must win: there is no strobe, the low drive starts again, and the earlier watchdog flag survives to set the final code. The bench counts cycles from the watchdog request to the negative edge just before the release edge and raises an illegal-address request there. It then checks that the strobe is absent, that the drive is back on, and that a full-length sequence ends with code 10. Random runs also place a second request at random points in the low drive and check the merged flag priority.

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int LOW_CYC    = 128,
  parameter int SYNC_N     = 3,
  parameter int SETTLE_CYC = 64
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       lvd_i,
  input  logic       bad_addr_i,
  input  logic       wdog_i,
  input  logic       cmon_i,
  input  logic       self_clk_i,
  input  logic       pin_i,
  output logic       pin_drv_o,
  output logic       rst_o,
  output logic       vec_vld_o,
  output logic [1:0] vec_sel_o
);

  localparam int DRV_CYC = LOW_CYC + SYNC_N;
  localparam int MAX_CYC = (DRV_CYC > SETTLE_CYC) ? DRV_CYC : SETTLE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  localparam logic [1:0] VEC_GEN  = 2'b00;
  localparam logic [1:0] VEC_CMON = 2'b01;
  localparam logic [1:0] VEC_WDOG = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_SETTLE, S_HOLD} st_t;

  initial begin
    if (SYNC_N < 3 || SYNC_N > 6)
      $error("reset_sequencer: SYNC_N must lie in 3..6, got %0d", SYNC_N);
  end

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    pin_q;
  logic          cm_pend, wd_pend;

  wire cm_hit = cmon_i & ~self_clk_i;
  wire req    = por_i | lvd_i | bad_addr_i | wdog_i | cm_hit;
  wire pin_s  = pin_q[1];

  wire drv_done    = (cnt == CW'(DRV_CYC - 1));
  wire settle_done = (cnt == CW'(SETTLE_CYC - 1));

  wire rel_sample = (st == S_SETTLE) && settle_done && pin_s;
  wire rel_hold   = (st == S_HOLD) && pin_s;
  wire release_now = !req && (rel_sample || rel_hold);

  logic [1:0] pick;
  always_comb begin
    if (rel_hold)     pick = VEC_GEN;
    else if (cm_pend) pick = VEC_CMON;
    else if (wd_pend) pick = VEC_WDOG;
    else              pick = VEC_GEN;
  end

  assign rst_o     = req | (st != S_IDLE);
  assign pin_drv_o = req | (st == S_DRIVE);

  always_ff @(posedge clk_i) pin_q <= {pin_q[0], pin_i};

  always_ff @(posedge clk_i) begin
    if (req) begin
      st  <= S_DRIVE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (!pin_s) begin
          st  <= S_DRIVE;
          cnt <= '0;
        end
        S_DRIVE: if (drv_done) begin
          st  <= S_SETTLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_SETTLE: if (settle_done) begin
          st  <= pin_s ? S_IDLE : S_HOLD;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_HOLD: if (pin_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      cm_pend   <= cm_hit;
      wd_pend   <= wdog_i;
      vec_vld_o <= 1'b0;
      vec_sel_o <= VEC_GEN;
    end else begin
      vec_vld_o <= release_now;
      if (cm_hit) cm_pend <= 1'b1;
      if (wdog_i) wd_pend <= 1'b1;
      if (release_now) begin
        vec_sel_o <= pick;
        cm_pend   <= 1'b0;
        wd_pend   <= 1'b0;
      end
    end
  end

endmodule

module reset_sequencer_chk #(
  parameter int LOW_CYC = 128,
  parameter int SYNC_N  = 3
) (
  input logic       clk_i,
  input logic       por_i,
  input logic       lvd_i,
  input logic       bad_addr_i,
  input logic       wdog_i,
  input logic       cmon_i,
  input logic       self_clk_i,
  input logic       pin_drv_o,
  input logic       rst_o,
  input logic       vec_vld_o,
  input logic [1:0] vec_sel_o
);
  localparam int DRV_CYC = LOW_CYC + SYNC_N;

  wire req = por_i | lvd_i | bad_addr_i | wdog_i | (cmon_i & ~self_clk_i);
  int drv_run;

  always_ff @(posedge clk_i) begin
    if (req || !pin_drv_o) drv_run <= 0;
    else                   drv_run <= drv_run + 1;
  end

  // R1
  async_entry_chk: assert property (@(posedge clk_i) disable iff (por_i)
    req |-> (rst_o && pin_drv_o));

  // R3
  drive_len_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(pin_drv_o) |-> (drv_run == DRV_CYC));

  // R10
  strobe_once_chk: assert property (@(posedge clk_i) disable iff (por_i)
    vec_vld_o |=> !vec_vld_o);

  // R10
  strobe_on_fall_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(rst_o) |-> vec_vld_o);

  // R10
  code_legal_chk: assert property (@(posedge clk_i) disable iff (por_i)
    vec_vld_o |-> (vec_sel_o != 2'b11 && !rst_o));
endmodule

bind reset_sequencer reset_sequencer_chk #(.LOW_CYC(LOW_CYC), .SYNC_N(SYNC_N)) u_chk (
  .clk_i(clk_i), .por_i(por_i), .lvd_i(lvd_i), .bad_addr_i(bad_addr_i),
  .wdog_i(wdog_i), .cmon_i(cmon_i), .self_clk_i(self_clk_i),
  .pin_drv_o(pin_drv_o), .rst_o(rst_o), .vec_vld_o(vec_vld_o),
  .vec_sel_o(vec_sel_o));

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
  localparam int LOW = 128, SN = 3, SET = 64;
  localparam int DRV = LOW + SN;

  logic clk = 0;
  always #5 clk = ~clk;

  logic por = 1, lvd = 0, bad = 0, wd = 0, cm = 0, sce = 0, ext_low = 0;
  logic drv, rst, vld;
  logic [1:0] sel;
  wire pin = !(drv | ext_low);

  int checks = 0, errors = 0;

  reset_sequencer #(.LOW_CYC(LOW), .SYNC_N(SN), .SETTLE_CYC(SET)) u_reset_sequencer (
    .clk_i(clk), .por_i(por), .lvd_i(lvd), .bad_addr_i(bad), .wdog_i(wd),
    .cmon_i(cm), .self_clk_i(sce), .pin_i(pin), .pin_drv_o(drv), .rst_o(rst),
    .vec_vld_o(vld), .vec_sel_o(sel));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] expect_vec(input logic c, input logic w);
    return c ? 2'b01 : (w ? 2'b10 : 2'b00);
  endfunction

  // m = {por, lvd, bad, wd, cm}
  task automatic fire(input logic [4:0] m);
    @(negedge clk);
    {por, lvd, bad, wd, cm} = m;
    #1;
    if (m[4:1] != 0 || (m[0] && !sce))
      check(rst && drv, "R1 async entry", {rst, drv}, 3);
    @(negedge clk);
    {por, lvd, bad, wd, cm} = 5'b0;
  endtask

  task automatic finish_seq(input logic [1:0] exp, input string tag);
    int n = 1, s = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!drv) break;
      n++;
    end
    check(n == DRV, "R3 drive length", n, DRV);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!rst) break;
      s++;
    end
    check(s == SET, "R5 settle length", s, SET);
    check(vld && sel == exp, tag, {vld, sel}, {1'b1, exp});
    @(negedge clk);
    check(!vld && sel == exp, "R10 strobe one cycle", {vld, sel}, {1'b0, exp});
  endtask

  task automatic quiet(input string tag);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!rst && !drv, tag, {rst, drv}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    check(rst && drv, "R1 power-on async", {rst, drv}, 3);
    repeat (3) @(negedge clk);
    por = 0;
    finish_seq(2'b00, "R9 power-on vector");

    fire(5'b00010); finish_seq(2'b10, "R8 watchdog vector");
    fire(5'b00100); finish_seq(2'b00, "R11 flags cleared");
    fire(5'b00001); finish_seq(2'b01, "R7 clock monitor vector");
    fire(5'b00011); finish_seq(2'b01, "R7 cmon over watchdog");

    sce = 1;
    fire(5'b00001);
    quiet("R2 masked clock monitor");
    fire(5'b00100); finish_seq(2'b00, "R2 no flag latched");
    sce = 0;

    fire(5'b00010);
    repeat (40) @(negedge clk);
    fire(5'b00100); finish_seq(2'b10, "R4 restart in drive");

    fire(5'b01000);
    for (int i = 0; i < 500; i++) begin @(negedge clk); if (!drv) break; end
    repeat (10) @(negedge clk);
    fire(5'b00001); finish_seq(2'b01, "R4 restart in settle");

    // request in the very cycle of the sample and release
    fire(5'b00010);
    repeat (DRV + SET - 2) @(negedge clk);
    fire(5'b00100);
    check(!vld && drv, "R4 same-cycle request wins", {vld, drv}, 1);
    finish_seq(2'b10, "R4 watchdog flag kept");

    // external pin held low past the sample point
    begin
      int k = 0;
      fire(5'b00010);
      finish_seq(2'b10, "R8 before pin test");
      @(negedge clk);
      ext_low = 1;
      for (int i = 0; i < 10; i++) begin @(negedge clk); k++; if (drv) break; end
      check(k == 3, "R12 pin entry latency", k, 3);
      repeat (DRV + SET + 20) @(negedge clk);
      check(rst && !vld, "R6 hold while pin low", {rst, vld}, 2);
      ext_low = 0;
      k = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); k++; if (!rst) break; end
      check(k == 3 && vld && sel == 2'b00, "R6 release after pin rise", k, 3);
    end

    // pin low at sample with a watchdog flag pending
    fire(5'b00010);
    repeat (DRV + 5) @(negedge clk);
    ext_low = 1;
    repeat (SET + 5) @(negedge clk);
    ext_low = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (!rst) break; end
    check(vld && sel == 2'b00, "R6 low sample beats flags", sel, 0);

    for (int it = 0; it < 16; it++) begin
      logic [4:0] m1, m2;
      logic c, w, eff;
      @(negedge clk);
      sce = 1'($urandom);
      m1 = 5'($urandom) & 5'b01111;
      eff = (m1[4:1] != 0) || (m1[0] && !sce);
      if (!eff) begin
        fire(m1);
        quiet("R2 random masked");
        continue;
      end
      fire(m1);
      c = m1[0] & !sce;
      w = m1[1];
      if ($urandom % 2) begin
        repeat ($urandom % (DRV - 10)) @(negedge clk);
        m2 = (5'($urandom) & 5'b11111) | 5'b00100;
        fire(m2);
        if (m2[4]) begin c = m2[0] & !sce; w = m2[1]; end
        else begin c = c | (m2[0] & !sce); w = w | m2[1]; end
      end
      finish_seq(expect_vec(c, w), "R7 R8 R9 random vector");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule